// File: doc/BRIEF.md
# Hybrid Resistor-Ladder DAC Driver with Modulated Fine Bits

This block turns a digital setpoint into drive levels for an external R/2R resistor ladder whose bottom rung has two inputs of the same weight: the regular bit-0 input and an extra one. The coarse, upper bits of the applied code sit on the regular ladder inputs as static levels. The fine, lower bits are delivered on the extra input as a carry stream. A phase accumulator adds the fine fraction every clock, and its carry-out is the bit that drives the extra input. Because only one LSB-weighted input toggles, the ripple left after the external low-pass filter is a small fraction of what a full-scale pulse-width signal would leave. With four static bits the reduction is sixteen-fold.

A new setpoint is not applied at once. The block latches it as a target and walks the applied code toward it by one count per update step. A prescaler fires one step every `STEP_DIV` clocks. Keeping each change to one code step lets the external filter capacitor be sized for a single-count transition. A busy flag stays high until the applied code equals the target. Writing a new target mid-ramp redirects the walk from wherever the applied code currently is.

Top module: `ldac_hybrid_drv`

## Requirements
- R1: While reset is asserted and right after it is released, `ladder_o` is 0, `spare_o` is 0 and `busy_o` is 0. The applied code, the target and the accumulator are all zero.
- R2: `ladder_o` equals bits [CODE_W-1 -: LADDER_W] of the applied code (bits 11..8 by default). It holds that value without toggling while the applied code is constant.
- R3: With the fine fraction f held constant (bits [FRAC_W-1:0] of the applied code, bits 7..0 by default), `spare_o` is high in exactly f of any 2^FRAC_W consecutive cycles. When f is 0 it is never high.
- R4: The applied code changes by exactly one count per step, always toward the target, and never jumps.
- R5: Steps occur at most once per `STEP_DIV` clocks. A ramp of d counts settles within d*STEP_DIV+2 cycles of the write.
- R6: `busy_o` is high exactly while the applied code differs from the target. Writing the value already applied leaves `busy_o` low.
- R7: A write during a ramp retargets it. The applied code continues from its current value toward the new target, which may reverse direction.
- R8: The full code range 0 to 2^CODE_W-1 is reachable in both directions, with no wrap at either end.
- R9: `target_i` is latched only in a cycle where `wr_i` is 1. Changes on `target_i` with `wr_i` at 0 have no effect.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| target_i | input | CODE_W | New setpoint code |
| wr_i | input | 1 | Latch `target_i` as the new target |
| ladder_o | output | LADDER_W | Static coarse ladder inputs; bit 0 is the regular LSB rung |
| spare_o | output | 1 | Modulated extra LSB-weight rung |
| busy_o | output | 1 | Applied code differs from target |

## Verification
On every cycle, the assertions check four things:
- the applied code moves by at most one count;
- successive moves are at least `STEP_DIV` clocks apart;
- the code is frozen whenever `busy_o` was low;
- a zero fraction never produces a carry on the extra rung.

Other behaviours need whole scenarios, so only the bench can show them. The exact duty count over a full accumulator period is swept across every fine value. The bench also covers the settling time of a ramp, direction reversal on a mid-ramp write, the ignored `target_i` without a strobe, and the two ends of the code range.

// File: rtl/ldac_pkg.sv
`timescale 1ns/1ps
package ldac_pkg;
  typedef enum logic [1:0] {
    SLEW_HOLD = 2'd0,
    SLEW_UP   = 2'd1,
    SLEW_DOWN = 2'd2
  } slew_dir_e;
endpackage

// File: rtl/ldac_step_tick.sv
`timescale 1ns/1ps
module ldac_step_tick #(
  parameter int STEP_DIV = 4
) (
  input  logic clk_i,
  input  logic rst_ni,
  output logic tick_o
);
  generate
    if (STEP_DIV <= 1) begin : g_every
      logic tick_q;
      always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) tick_q <= 1'b0;
        else         tick_q <= 1'b1;
      end
      assign tick_o = tick_q;
    end else begin : g_div
      localparam int CNT_W = $clog2(STEP_DIV);
      localparam logic [CNT_W-1:0] LAST = CNT_W'(STEP_DIV - 1);
      logic [CNT_W-1:0] cnt_q;
      always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni)            cnt_q <= '0;
        else if (cnt_q == LAST) cnt_q <= '0;
        else                    cnt_q <= cnt_q + 1'b1;
      end
      assign tick_o = (cnt_q == LAST);
    end
  endgenerate
endmodule

// File: rtl/ldac_slew.sv
`timescale 1ns/1ps
module ldac_slew
  import ldac_pkg::*;
#(
  parameter int CODE_W = 12
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              step_i,
  input  logic              wr_i,
  input  logic [CODE_W-1:0] target_i,
  output logic [CODE_W-1:0] code_o,
  output logic              busy_o
);
  logic [CODE_W-1:0] tgt_q, code_q;
  slew_dir_e         dir;

  always_comb begin
    if (code_q < tgt_q)      dir = SLEW_UP;
    else if (code_q > tgt_q) dir = SLEW_DOWN;
    else                     dir = SLEW_HOLD;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)   tgt_q <= '0;
    else if (wr_i) tgt_q <= target_i;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) code_q <= '0;
    else if (step_i) begin
      case (dir)
        SLEW_UP:   code_q <= code_q + 1'b1;
        SLEW_DOWN: code_q <= code_q - 1'b1;
        default:   code_q <= code_q;
      endcase
    end
  end

  assign code_o = code_q;
  assign busy_o = (dir != SLEW_HOLD);
endmodule

// File: rtl/ldac_frac_mod.sv
`timescale 1ns/1ps
module ldac_frac_mod #(
  parameter int FRAC_W = 8
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic [FRAC_W-1:0] frac_i,
  output logic              bit_o
);
  logic [FRAC_W-1:0] acc_q;
  logic [FRAC_W:0]   sum;
  logic              bit_q;

  assign sum = {1'b0, acc_q} + {1'b0, frac_i};

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      acc_q <= '0;
      bit_q <= 1'b0;
    end else begin
      acc_q <= sum[FRAC_W-1:0];
      bit_q <= sum[FRAC_W];
    end
  end

  assign bit_o = bit_q;
endmodule

// File: rtl/ldac_hybrid_drv.sv
`timescale 1ns/1ps
module ldac_hybrid_drv #(
  parameter int CODE_W   = 12,
  parameter int LADDER_W = 4,
  parameter int STEP_DIV = 4
) (
  input  logic                clk_i,
  input  logic                rst_ni,
  input  logic [CODE_W-1:0]   target_i,
  input  logic                wr_i,
  output logic [LADDER_W-1:0] ladder_o,
  output logic                spare_o,
  output logic                busy_o
);
  localparam int FRAC_W = CODE_W - LADDER_W;

  logic              step;
  logic [CODE_W-1:0] code;

  ldac_step_tick #(.STEP_DIV(STEP_DIV)) u_tick (
    .clk_i (clk_i),
    .rst_ni(rst_ni),
    .tick_o(step)
  );

  ldac_slew #(.CODE_W(CODE_W)) u_slew (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .step_i  (step),
    .wr_i    (wr_i),
    .target_i(target_i),
    .code_o  (code),
    .busy_o  (busy_o)
  );

  // fine bits ride the extra LSB-weight rung
  ldac_frac_mod #(.FRAC_W(FRAC_W)) u_mod (
    .clk_i (clk_i),
    .rst_ni(rst_ni),
    .frac_i(code[FRAC_W-1:0]),
    .bit_o (spare_o)
  );

  assign ladder_o = code[CODE_W-1 -: LADDER_W];
endmodule

// File: rtl/ldac_hybrid_chk.sv
`timescale 1ns/1ps
module ldac_hybrid_chk #(
  parameter int CODE_W   = 12,
  parameter int LADDER_W = 4,
  parameter int STEP_DIV = 4
) (
  input logic              clk_i,
  input logic              rst_ni,
  input logic [CODE_W-1:0] code_i,
  input logic              spare_i,
  input logic              busy_i
);
  localparam int FRAC_W = CODE_W - LADDER_W;
  localparam int GAP_W  = $clog2(STEP_DIV + 2);

  logic [CODE_W-1:0] code_d;
  logic [GAP_W-1:0]  gap_q;
  logic              moved;

  assign moved = (code_i != code_d);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      code_d <= '0;
      gap_q  <= '0;
    end else begin
      code_d <= code_i;
      if (moved)                        gap_q <= '0;
      else if (int'(gap_q) < STEP_DIV)  gap_q <= gap_q + 1'b1;
    end
  end

  // R4
  one_count_step_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (code_i == $past(code_i)) || (code_i == $past(code_i) + 1'b1) ||
    (code_i == $past(code_i) - 1'b1));

  // R5
  step_spacing_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    moved |-> (int'(gap_q) >= STEP_DIV - 1));

  // R6
  idle_frozen_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !busy_i |=> $stable(code_i));

  // R3
  zero_frac_quiet_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (code_i[FRAC_W-1:0] == '0) |=> !spare_i);
endmodule

bind ldac_hybrid_drv ldac_hybrid_chk #(
  .CODE_W(CODE_W), .LADDER_W(LADDER_W), .STEP_DIV(STEP_DIV)
) u_chk (
  .clk_i  (clk_i),
  .rst_ni (rst_ni),
  .code_i (code),
  .spare_i(spare_o),
  .busy_i (busy_o)
);

// File: tb/ldac_hybrid_drv_tb.sv
`timescale 1ns/1ps
module ldac_hybrid_drv_tb;
  localparam int S = 2;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [11:0] target = '0;
  logic        wr = 1'b0;
  logic [3:0]  ladder;
  logic        spare, busy;

  int checks = 0, failures = 0;
  int cur = 0;

  always #2.5 clk = ~clk;

  ldac_hybrid_drv #(.CODE_W(12), .LADDER_W(4), .STEP_DIV(S)) u_dut (
    .clk_i(clk), .rst_ni(rst_n), .target_i(target), .wr_i(wr),
    .ladder_o(ladder), .spare_o(spare), .busy_o(busy)
  );

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      failures++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic write_code(input int c);
    @(negedge clk); target = 12'(c); wr = 1'b1;
    @(negedge clk); wr = 1'b0;
  endtask

  task automatic settle(input int max_n, input string req);
    int n = 0;
    while (busy) begin @(negedge clk); n++; end
    chk(n <= max_n, req, n, max_n);
  endtask

  task automatic measure(input int c, input string req);
    int ones = 0;
    bit steady = 1'b1;
    logic [3:0] l0;
    @(negedge clk);
    l0 = ladder;
    for (int i = 0; i < 256; i++) begin
      if (spare) ones++;
      if (ladder != l0) steady = 1'b0;
      @(negedge clk);
    end
    chk(l0 == 4'(c >> 8), {req, " R2 ladder"}, l0, c >> 8);
    chk(steady, "R2 ladder static", 0, 1);
    chk(ones == (c & 255), {req, " R3 duty"}, ones, c & 255);
  endtask

  task automatic go(input int c, input string req);
    int d = (c > cur) ? c - cur : cur - c;
    write_code(c);
    settle(d * S + 2, {req, " R5 settle"});
    cur = c;
    measure(c, req);
  endtask

  initial begin
    repeat (190000) @(posedge clk);
    failures++;
    $display("FAIL watchdog expired actual=0 expected=1");
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    // R1 during reset
    chk(ladder == 0 && !spare && !busy, "R1 in reset", {ladder, spare, busy}, 0);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
    chk(ladder == 0 && !spare && !busy, "R1 after reset", {ladder, spare, busy}, 0);

    // R3 R5: every fine value, one-count ramps (R4)
    for (int f = 0; f < 256; f++) go(f, "R4 sweep");

    go(12'h310, "R8 up");
    go(12'h0A5, "R4 down");
    go(12'hFFF, "R8 top");

    // R6: rewrite of the applied value
    write_code(12'hFFF);
    chk(!busy, "R6 same value", busy, 0);

    // R9: target_i without strobe
    target = 12'h000;
    repeat (20) @(negedge clk);
    chk(!busy && ladder == 4'hF, "R9 no strobe", {busy, ladder}, 15);

    // R7: retarget mid-ramp, reversing direction
    write_code(12'h800);
    repeat (100) @(negedge clk);
    chk(busy, "R7 mid-ramp busy", busy, 1);
    write_code(12'hFF0);
    chk(busy, "R7 retarget busy", busy, 1);
    settle(120, "R7 settle");
    cur = 12'hFF0;
    measure(12'hFF0, "R7 final");

    go(0, "R8 bottom");

    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule